// File: doc/BRIEF.md
# Buffered Event Forwarder with Trigger Throttle

This block sits on the receive side of a serial data link. It takes packets that have already been deserialized and framed, one word per beat. Each packet opens with a header word. Packets flagged as slow control in the header pass out on a side port. All other packets are events. Events go into an event buffer and are counted once they are complete. A transfer engine drains the buffer one whole event at a time into a host readout FIFO, and it pauses while that FIFO reports full.

Transmission faults do not drop data. If the end-of-packet check fails, or a packet is cut short by the next header, the event is still forwarded and its header carries an error bit for later monitoring. A busy output goes high when the number of stored events exceeds a threshold that software programs. Busy drops again two clocks after an event leaves the buffer, provided the count is back at or under the threshold.

The ingress machine has three states:
- RX_IDLE: waiting for a header.
- RX_EVT: collecting an event.
- RX_SCTL: passing slow control.

Its transitions are:
- open: a header arrives.
- close: the end beat arrives.
- cut: a header arrives while an event is open.
- drop: a stray beat arrives in RX_IDLE.

The transfer machine has two states:
- DR_IDLE: waits until the stored-event count is non-zero, then loads the event length ("start").
- DR_SEND: writes one word per cycle that the host is not full, and returns to DR_IDLE after the last word ("finish").

The sender must honour busy. The buffer holds `SLOTS` events of up to `MAX_WORDS` words each, and an event must not exceed `MAX_WORDS` words including its header.

Top module: `evt_forwarder`

## Requirements
- R1: Each event reaches the host FIFO in arrival order as its header word followed by its payload words unchanged, except that header bit 15 carries the error flag.
- R2: An event whose last beat has `in_crc_bad` high is forwarded complete, with header bit 15 set to 1; a clean event has header bit 15 set to 0.
- R3: A header beat (`in_first`) that arrives while an event is still open closes that event. The closed event is forwarded with the words received so far and with header bit 15 set.
- R4: A packet whose header has bit 14 set is slow control. Each of its beats appears on `sc_valid`/`sc_data`/`sc_last` one clock after it is accepted, and none of its words reach the host FIFO or the stored-event count.
- R5: `host_we` is never high while `host_full` is high, and no word is lost or repeated across a full stall.
- R6: The host FIFO is written only when at least one complete event is stored. Beats that arrive without a preceding header (while no packet is open) are ignored.
- R7: When the stored-event count exceeds `thresh`, `busy` is high from the second clock after the commit that raised the count.
- R8: After the last word of an event is written with `host_we`, `busy` stays high for one more clock and is low from the second clock on, if the count is then at or under `thresh`.
- R9: A packet with `in_first` and `in_last` on the same beat is a one-word event and is forwarded as its header alone.
- R10: During reset `busy`, `host_we` and `sc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for ingress, buffer and host side |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet beat present |
| in_first | input | 1 | Beat is a header word |
| in_last | input | 1 | Beat closes the packet |
| in_crc_bad | input | 1 | End check failed; sampled on the closing beat |
| in_data | input | DW | Packet word; in headers bit 14 marks slow control |
| thresh | input | 8 | Stored-event count above which busy is raised |
| host_full | input | 1 | Host FIFO cannot accept a word |
| host_we | output | 1 | Host FIFO write strobe |
| host_wdata | output | DW | Word written to the host FIFO |
| busy | output | 1 | Trigger throttle |
| sc_valid | output | 1 | Slow-control beat present |
| sc_data | output | DW | Slow-control word |
| sc_last | output | 1 | Slow-control packet ends on this beat |

## Verification
The stimulus mixes these packet types:
- clean events of one to eight words;
- events that end with a bad check;
- events cut short by the next header;
- one-word events;
- slow-control packets;
- stray beats with no header.

Comparing each host word against the expected stream tells apart the three header-error cases and shows that slow control never leaks into the event path. A random full pattern on the host side stalls transfers mid-event, which separates a correct stall (no word lost or repeated) from one that drops data. A directed run with a threshold of one pins the exact clocks at which busy rises and falls, so a release that comes one cycle early or late shows up.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    // Width of the stored-event counter and of the busy threshold.
    localparam int CNT_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_EVT,
        RX_SCTL
    } rx_state_e;

    typedef enum logic {
        DR_IDLE,
        DR_SEND
    } dr_state_e;
endpackage

// File: rtl/fwd_rx_packer.sv
// Ingress machine.
// The header word is held back and written at close time, together with the
// event length and the error flag. Payload words are written as they arrive.
module fwd_rx_packer
    import fwd_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic          in_crc_bad,
    input  logic [DW-1:0] in_data,
    output logic          a_we,
    output logic [AW-1:0] a_addr,
    output logic [DW-1:0] a_data,
    output logic [LW-1:0] a_len,
    output logic          b_we,
    output logic [AW-1:0] b_addr,
    output logic [DW-1:0] b_data,
    output logic [LW-1:0] b_len,
    output logic [1:0]    commit_n,
    output logic          sc_valid,
    output logic [DW-1:0] sc_data,
    output logic          sc_last
);
    localparam int ERR_BIT = DW - 1;
    localparam int SC_BIT  = DW - 2;

    rx_state_e     st_q, st_d;
    logic [DW-1:0] hdr_q, hdr_d;
    logic [AW-1:0] hdr_addr_q, hdr_addr_d;
    logic [AW-1:0] wr_ptr_q, wr_ptr_d;
    logic [LW-1:0] len_q, len_d;
    logic          sc_beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= RX_IDLE;
            hdr_q      <= '0;
            hdr_addr_q <= '0;
            wr_ptr_q   <= '0;
            len_q      <= '0;
            sc_valid   <= 1'b0;
            sc_data    <= '0;
            sc_last    <= 1'b0;
        end else begin
            st_q       <= st_d;
            hdr_q      <= hdr_d;
            hdr_addr_q <= hdr_addr_d;
            wr_ptr_q   <= wr_ptr_d;
            len_q      <= len_d;
            sc_valid   <= sc_beat;
            sc_data    <= in_data;
            sc_last    <= in_last;
        end
    end

    always_comb begin
        st_d       = st_q;
        hdr_d      = hdr_q;
        hdr_addr_d = hdr_addr_q;
        wr_ptr_d   = wr_ptr_q;
        len_d      = len_q;
        a_we       = 1'b0;
        a_addr     = hdr_addr_q;
        a_data     = hdr_q;
        a_len      = len_q;
        b_we       = 1'b0;
        b_addr     = wr_ptr_q;
        b_data     = in_data;
        b_len      = '0;
        commit_n   = 2'd0;
        sc_beat    = 1'b0;
        if (in_valid) begin
            if (in_first) begin
                // cut: an open event is closed as erroneous
                if (st_q == RX_EVT) begin
                    a_we            = 1'b1;
                    a_data[ERR_BIT] = 1'b1;
                    commit_n        = 2'd1;
                end
                if (in_data[SC_BIT]) begin
                    sc_beat = 1'b1;
                    st_d    = in_last ? RX_IDLE : RX_SCTL;
                end else if (in_last) begin
                    // one-word event goes straight into the buffer
                    b_we            = 1'b1;
                    b_data[ERR_BIT] = in_crc_bad;
                    b_len           = LW'(1);
                    wr_ptr_d        = wr_ptr_q + AW'(1);
                    commit_n        = commit_n + 2'd1;
                    st_d            = RX_IDLE;
                end else begin
                    // open: reserve the header slot
                    hdr_d      = in_data;
                    hdr_addr_d = wr_ptr_q;
                    wr_ptr_d   = wr_ptr_q + AW'(1);
                    len_d      = LW'(1);
                    st_d       = RX_EVT;
                end
            end else begin
                unique case (st_q)
                    RX_EVT: begin
                        b_we     = 1'b1;
                        wr_ptr_d = wr_ptr_q + AW'(1);
                        len_d    = len_q + LW'(1);
                        if (in_last) begin
                            // close
                            a_we            = 1'b1;
                            a_len           = len_q + LW'(1);
                            a_data[ERR_BIT] = in_crc_bad;
                            commit_n        = 2'd1;
                            st_d            = RX_IDLE;
                        end
                    end
                    RX_SCTL: begin
                        sc_beat = 1'b1;
                        if (in_last) st_d = RX_IDLE;
                    end
                    RX_IDLE: begin
                        // drop: stray beat
                    end
                    default: st_d = RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fwd_evt_store.sv
// Event buffer. Each entry holds a length field (meaningful only in header
// entries) and a data word. There are two write ports (header close and
// streaming word) and one asynchronous read port.
module fwd_evt_store #(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_data,
    input  logic [LW-1:0] a_len,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_data,
    input  logic [LW-1:0] b_len,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [LW-1:0] rd_len
);
    localparam int DEPTH = 1 << AW;

    logic [LW+DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= {a_len, a_data};
        if (b_we) mem[b_addr] <= {b_len, b_data};
    end

    assign {rd_len, rd_data} = mem[rd_addr];
endmodule

// File: rtl/fwd_evt_drain.sv
// Transfer machine: moves one whole event at a time into the host FIFO.
module fwd_evt_drain
    import fwd_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 6,
    parameter int LW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] evt_count,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    input  logic [LW-1:0]    rd_len,
    input  logic             host_full,
    output logic             host_we,
    output logic [DW-1:0]    host_wdata,
    output logic             xfer_done
);
    dr_state_e     st_q, st_d;
    logic [AW-1:0] rd_q, rd_d;
    logic [LW-1:0] rem_q, rem_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DR_IDLE;
            rd_q  <= '0;
            rem_q <= '0;
        end else begin
            st_q  <= st_d;
            rd_q  <= rd_d;
            rem_q <= rem_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        rd_d      = rd_q;
        rem_d     = rem_q;
        host_we   = 1'b0;
        xfer_done = 1'b0;
        unique case (st_q)
            DR_IDLE: begin
                // start
                if (evt_count != '0) begin
                    rem_d = rd_len;
                    st_d  = DR_SEND;
                end
            end
            DR_SEND: begin
                if (!host_full) begin
                    host_we = 1'b1;
                    rd_d    = rd_q + AW'(1);
                    rem_d   = rem_q - LW'(1);
                    // finish
                    if (rem_q == LW'(1)) begin
                        xfer_done = 1'b1;
                        st_d      = DR_IDLE;
                    end
                end
            end
            default: st_d = DR_IDLE;
        endcase
    end

    assign rd_addr    = rd_q;
    assign host_wdata = rd_data;
endmodule

// File: rtl/fwd_busy_ctl.sv
// Stored-event counter and trigger throttle.
module fwd_busy_ctl
    import fwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       commit_n,
    input  logic             xfer_done,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] evt_count,
    output logic             busy
);
    logic done_d1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_count <= '0;
            done_d1   <= 1'b0;
            busy      <= 1'b0;
        end else begin
            evt_count <= evt_count + CNT_W'(commit_n) - CNT_W'(xfer_done);
            done_d1   <= xfer_done;
            if (evt_count > thresh) busy <= 1'b1;
            else if (done_d1)       busy <= 1'b0;
        end
    end
endmodule

// File: rtl/evt_forwarder.sv
module evt_forwarder
    import fwd_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MAX_WORDS = 8,
    parameter int SLOTS     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic             in_crc_bad,
    input  logic [DW-1:0]    in_data,
    input  logic [CNT_W-1:0] thresh,
    input  logic             host_full,
    output logic             host_we,
    output logic [DW-1:0]    host_wdata,
    output logic             busy,
    output logic             sc_valid,
    output logic [DW-1:0]    sc_data,
    output logic             sc_last
);
    // MAX_WORDS * SLOTS must be a power of two so that the pointers wrap.
    localparam int DEPTH = MAX_WORDS * SLOTS;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(MAX_WORDS + 1);

    logic             a_we, b_we;
    logic [AW-1:0]    a_addr, b_addr, rd_addr;
    logic [DW-1:0]    a_data, b_data, rd_data;
    logic [LW-1:0]    a_len, b_len, rd_len;
    logic [1:0]       commit_n;
    logic             xfer_done;
    logic [CNT_W-1:0] evt_count;

    fwd_rx_packer #(.DW(DW), .AW(AW), .LW(LW)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
        .in_crc_bad(in_crc_bad), .in_data(in_data),
        .a_we(a_we), .a_addr(a_addr), .a_data(a_data), .a_len(a_len),
        .b_we(b_we), .b_addr(b_addr), .b_data(b_data), .b_len(b_len),
        .commit_n(commit_n),
        .sc_valid(sc_valid), .sc_data(sc_data), .sc_last(sc_last)
    );

    fwd_evt_store #(.DW(DW), .AW(AW), .LW(LW)) u_store (
        .clk(clk),
        .a_we(a_we), .a_addr(a_addr), .a_data(a_data), .a_len(a_len),
        .b_we(b_we), .b_addr(b_addr), .b_data(b_data), .b_len(b_len),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_len(rd_len)
    );

    fwd_evt_drain #(.DW(DW), .AW(AW), .LW(LW)) u_drain (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_len(rd_len),
        .host_full(host_full), .host_we(host_we), .host_wdata(host_wdata),
        .xfer_done(xfer_done)
    );

    fwd_busy_ctl u_busy (
        .clk(clk), .rst_n(rst_n), .commit_n(commit_n), .xfer_done(xfer_done),
        .thresh(thresh), .evt_count(evt_count), .busy(busy)
    );
endmodule

// File: rtl/evt_fwd_checker.sv
module evt_fwd_checker
    import fwd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_we,
    input logic             host_full,
    input logic             busy,
    input logic [CNT_W-1:0] thresh,
    input logic [CNT_W-1:0] evt_count,
    input logic             xfer_done
);
    // R5
    a_r5_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |-> !host_full);

    // R6
    a_r6_done_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (evt_count != '0));

    // R7
    a_r7_busy_over_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count > thresh) |=> busy);

    // R8
    a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(xfer_done, 2));

    // R10
    a_r10_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> (!busy && !host_we) || !rst_n);
endmodule

bind evt_forwarder evt_fwd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_full(host_full),
    .busy(busy), .thresh(thresh), .evt_count(evt_count), .xfer_done(xfer_done)
);

// File: tb/sim_evt_forwarder.sv
`timescale 1ns/1ps
module sim_evt_forwarder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_crc_bad = 1'b0;
    logic [15:0] in_data = '0;
    logic [7:0]  thresh = 8'd5;
    logic        host_full = 1'b0;
    logic        host_we, busy, sc_valid, sc_last;
    logic [15:0] host_wdata, sc_data;

    always #2.5 clk = ~clk;

    evt_forwarder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_crc_bad(in_crc_bad), .in_data(in_data),
        .thresh(thresh), .host_full(host_full), .host_we(host_we),
        .host_wdata(host_wdata), .busy(busy), .sc_valid(sc_valid),
        .sc_data(sc_data), .sc_last(sc_last)
    );

    int          n_chk = 0, n_bad = 0, hw_cnt = 0, seq = 0;
    bit          rnd_full = 1'b0;
    logic [15:0] exp_q[$];
    string       exp_tag[$];
    logic [16:0] sc_q[$];

    task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (host_we) begin
                logic [15:0] e;
                string       t;
                hw_cnt++;
                if (exp_q.size() == 0) chk("R6 host write with nothing stored", 1'b0, host_wdata, 0);
                else begin
                    e = exp_q.pop_front();
                    t = exp_tag.pop_front();
                    chk(t, (host_wdata == e) && !host_full, {15'd0, host_full, host_wdata}, e);
                end
            end
            if (sc_valid) begin
                logic [16:0] s;
                if (sc_q.size() == 0) chk("R4 unexpected slow-control beat", 1'b0, {sc_last, sc_data}, 0);
                else begin
                    s = sc_q.pop_front();
                    chk("R4 slow-control beat", {sc_last, sc_data} == s, {sc_last, sc_data}, s);
                end
            end
        end
    end

    // Random full pattern for the host FIFO
    initial forever begin
        @(posedge clk); #1;
        if (rnd_full) host_full = ($urandom_range(3) == 0);
    end

    task automatic beat(input bit f, input bit l, input bit crc, input logic [15:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_first = f; in_last = l; in_crc_bad = crc; in_data = d;
    endtask

    task automatic idle_beat();
        @(posedge clk); #1;
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_crc_bad = 1'b0; in_data = '0;
    endtask

    // Header: bit 15 error flag (set by the block), bit 14 slow-control kind
    task automatic send_event(input int len, input bit crc, input bit trunc);
        logic [15:0] h;
        string       t;
        h = {2'b00, 14'(seq)};
        seq++;
        if (trunc)         t = "R3 header of cut-short event";
        else if (crc)      t = "R2 header of bad-check event";
        else if (len == 1) t = "R9 one-word event";
        else               t = "R1 header";
        exp_q.push_back({trunc | crc, h[14:0]});
        exp_tag.push_back(t);
        for (int i = 0; i < len; i++) begin
            logic [15:0] w;
            bit          last;
            last = (i == len - 1) && !trunc;
            w = (i == 0) ? h : 16'($urandom);
            if (i != 0) begin
                exp_q.push_back(w);
                exp_tag.push_back("R1 payload");
            end
            beat(i == 0, last, last & crc, w);
        end
        idle_beat();
    endtask

    task automatic send_sc(input int len);
        for (int i = 0; i < len; i++) begin
            logic [15:0] w;
            bit          last;
            last = (i == len - 1);
            w = (i == 0) ? {2'b01, 14'($urandom)} : 16'($urandom);
            sc_q.push_back({last, w});
            beat(i == 0, last, 1'b0, w);
        end
        idle_beat();
    endtask

    task automatic wait_drain();
        int k;
        k = 0;
        while ((exp_q.size() != 0 || sc_q.size() != 0) && k < 3000) begin
            @(posedge clk); #1;
            k++;
        end
        repeat (4) @(posedge clk);
        #1;
        chk("R1 every expected word delivered", (exp_q.size() == 0) && (sc_q.size() == 0),
            exp_q.size() + sc_q.size(), 0);
    endtask

    initial begin
        int base, got;
        void'($urandom(32'h0000_51ED));
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 busy in reset", busy == 1'b0, busy, 0);
        chk("R10 host_we in reset", host_we == 1'b0, host_we, 0);
        chk("R10 sc_valid in reset", sc_valid == 1'b0, sc_valid, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // Directed patterns
        send_event(4, 1'b0, 1'b0);
        send_event(1, 1'b0, 1'b0);
        send_event(3, 1'b1, 1'b0);
        send_event(3, 1'b0, 1'b1);
        send_event(2, 1'b0, 1'b0);
        send_event(1, 1'b1, 1'b1);
        send_sc(3);
        send_sc(1);
        send_event(5, 1'b0, 1'b0);
        wait_drain();

        // R6: stray beats with no header are ignored
        base = hw_cnt;
        beat(1'b0, 1'b0, 1'b0, 16'h1234);
        beat(1'b0, 1'b1, 1'b0, 16'h5678);
        idle_beat();
        repeat (20) @(posedge clk);
        #1;
        chk("R6 stray beats write nothing", hw_cnt == base, hw_cnt - base, 0);

        // R5 / R7 / R8: busy timing with threshold 1
        thresh = 8'd1;
        host_full = 1'b1;
        send_event(2, 1'b0, 1'b0);
        send_event(3, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 busy not yet set one clock after commit", busy == 1'b0, busy, 0);
        @(negedge clk);
        chk("R7 busy set when count exceeds threshold", busy == 1'b1, busy, 1);
        base = hw_cnt;
        repeat (10) @(posedge clk);
        #1;
        chk("R5 no write while host full", hw_cnt == base, hw_cnt - base, 0);
        host_full = 1'b0;
        got = 0;
        while (got < 2) begin
            @(negedge clk);
            if (host_we) got++;
        end
        @(negedge clk);
        chk("R8 busy held one clock after transfer", busy == 1'b1, busy, 1);
        @(negedge clk);
        chk("R8 busy released two clocks after transfer", busy == 1'b0, busy, 0);
        wait_drain();

        // Random mix
        thresh = 8'd4;
        rnd_full = 1'b1;
        for (int it = 0; it < 150; it++) begin
            int kind;
            kind = $urandom_range(9);
            while (busy) begin
                @(posedge clk); #1;
            end
            if (kind < 2) send_sc(1 + $urandom_range(3));
            else send_event(1 + $urandom_range(7), $urandom_range(4) == 0, $urandom_range(5) == 0);
            repeat ($urandom_range(2)) idle_beat();
        end
        send_event(2, 1'b0, 1'b0);
        rnd_full = 1'b0;
        host_full = 1'b0;
        wait_drain();
        chk("R8 busy low once drained", busy == 1'b0, busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 run did not finish actual=%0d expected=%0d", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule